// File: doc/BRIEF.md
# Two-Stage Timer Time-Base Generator

This block supplies the timing references for a programmable timer engine, all derived from one system clock. The first stage divides the system clock by a programmable high-resolution (HR) factor and gives a one-cycle enable, the HR tick. The HR tick is the finest step at which the engine may change an output pin or timestamp an input edge. The second stage counts HR ticks and gives a one-cycle loop-start enable once per loop period. Because it counts HR ticks, the loop period is a multiple of the HR period and not of the system clock.

Alongside the enables, the block reports the execution-slot budget of the loop in progress. This is the number of system-clock cycles in one loop period. It also exposes the current HR phase, so that pin timing can be placed inside an HR period.

A new prescale code is taken only at a loop boundary, so a running loop always completes with the length it started with. When the block is disabled, both counters stay cleared and no enables are produced.

Top module: `tbase_gen`

## Requirements
- R1: A synchronous active-high `rst` clears `hr_tick`, `loop_start` and `hr_phase` to 0, and loads `slots` with `(hr_code+1) * 2**lr_code` from the codes present during reset. After `rst` falls with `en` high, the run starts as described in R2.
- R2: Count the rising clock edges at which `en` is sampled high as 1, 2, 3 and so on. Let `d = hr_code+1`, a range of 1 to 64. `hr_tick` is high in the cycle after edge n exactly when n is a multiple of `d`.
- R3: Let `L = 2**lr_code`, a range of 1 to 128. `loop_start` is high only together with `hr_tick`. It is high in the cycle after edge n exactly when n is a multiple of `d*L`, so the first loop start comes one full loop period after enabling.
- R4: `slots` equals `d*L` for the loop in progress. While running, it takes the new value in the same cycle that `loop_start` goes high. While `en` is low, it follows the input codes with one cycle of delay.
- R5: A change of `hr_code` or `lr_code` in the middle of a loop has no effect on `hr_tick`, `loop_start`, `hr_phase` or `slots` until the next `loop_start`. The codes present at the edge that ends the loop govern the following loop.
- R6: While `en` is low, `hr_tick` and `loop_start` stay 0 and `hr_phase` stays 0.
- R7: `hr_phase` counts 0, 1, …, `d-1` once per HR period, and it reads 0 in every cycle where `hr_tick` is high.
- R8: The extreme settings work without overflow. `hr_code=63` with `lr_code=7` gives `slots=8192` and one loop start every 8192 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; when low, the counters are held cleared |
| hr_code | input | 6 | HR divide code; the divide is code+1 |
| lr_code | input | 3 | Loop divide code; the divide is 2**code |
| hr_tick | output | 1 | One-cycle HR enable |
| loop_start | output | 1 | One-cycle loop-start enable, coincident with an HR tick |
| hr_phase | output | 6 | Current position inside the HR period |
| slots | output | 14 | System cycles in the current loop period |

## Verification
A wrong HR counter state appears at once on `hr_phase`, and within one HR period as an `hr_tick` at the wrong distance. A wrong loop counter or a wrong latched code stays hidden until the end of the loop in progress. There it shows as a `loop_start` at the wrong edge, or as a `slots` value that differs from `d*L`, so the bench checks every output in every cycle over whole loops. It also changes codes mid-loop, which catches a latch that loads too early: that fault shows within one HR period as a changed tick spacing.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  // width of the loop tick counter for a given loop code width
  function automatic int lr_cnt_w(int code_w);
    int w;
    w = (1 << code_w) - 1;
    return (w < 1) ? 1 : w;
  endfunction

  // width able to hold (2**hr_w) * 2**(2**lr_w - 1)
  function automatic int slot_w(int hr_w, int lr_w);
    return hr_w + lr_cnt_w(lr_w) + 1;
  endfunction
endpackage

// File: rtl/tbase_code_latch.sv
module tbase_code_latch #(
  parameter int HR_CODE_W = 6,
  parameter int LR_CODE_W = 3,
  localparam int SLOT_W = tbase_pkg::slot_w(HR_CODE_W, LR_CODE_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [HR_CODE_W-1:0] hr_in,
  input  logic [LR_CODE_W-1:0] lr_in,
  output logic [HR_CODE_W-1:0] hr_act,
  output logic [LR_CODE_W-1:0] lr_act,
  output logic [SLOT_W-1:0]    slots
);
  logic [SLOT_W-1:0] base;
  logic [SLOT_W-1:0] next_slots;

  always_comb begin
    base       = SLOT_W'(hr_in) + SLOT_W'(1);
    next_slots = base << lr_in;
  end

  // reset and load both capture the live codes, so a run begun straight
  // out of reset uses the codes that were present during reset
  always_ff @(posedge clk) begin
    if (rst || load) begin
      hr_act <= hr_in;
      lr_act <= lr_in;
      slots  <= next_slots;
    end
  end
endmodule

// File: rtl/tbase_hr_div.sv
module tbase_hr_div #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CODE_W-1:0] div_code,
  output logic              tick,
  output logic [CODE_W-1:0] phase,
  output logic              wrap
);
  // last cycle of the HR period: the register below raises tick next cycle
  assign wrap = en && (phase == div_code);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= wrap;
      phase <= wrap ? '0 : phase + 1'b1;
    end
  end

  // R7: the phase never runs past the active divide code
  a_r7_phase_bound: assert property (@(posedge clk) disable iff (rst)
    phase <= div_code);

  // R7: a tick is always seen at phase zero
  a_r7_tick_phase: assert property (@(posedge clk) disable iff (rst)
    tick |-> (phase == '0));
endmodule

// File: rtl/tbase_loop_div.sv
module tbase_loop_div #(
  parameter int CODE_W = 3,
  localparam int CNT_W = tbase_pkg::lr_cnt_w(CODE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              hr_wrap,
  input  logic [CODE_W-1:0] div_code,
  output logic              loop_start,
  output logic              wrap
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] shifted;
  logic [CNT_W-1:0] last;

  always_comb begin
    shifted = {CNT_W{1'b1}} << div_code;
    last    = ~shifted;
  end

  assign wrap = hr_wrap && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt        <= '0;
      loop_start <= 1'b0;
    end else begin
      loop_start <= wrap;
      if (hr_wrap) cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tbase_gen.sv
module tbase_gen #(
  parameter int HR_CODE_W = 6,
  parameter int LR_CODE_W = 3,
  localparam int SLOT_W = tbase_pkg::slot_w(HR_CODE_W, LR_CODE_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [HR_CODE_W-1:0] hr_code,
  input  logic [LR_CODE_W-1:0] lr_code,
  output logic                 hr_tick,
  output logic                 loop_start,
  output logic [HR_CODE_W-1:0] hr_phase,
  output logic [SLOT_W-1:0]    slots
);
  logic [HR_CODE_W-1:0] hr_act;
  logic [LR_CODE_W-1:0] lr_act;
  logic                 hr_wrap;
  logic                 loop_wrap;
  logic                 load;

  // codes follow the inputs while idle and are taken only at loop end while running
  assign load = !en || loop_wrap;

  tbase_code_latch #(.HR_CODE_W(HR_CODE_W), .LR_CODE_W(LR_CODE_W)) i_latch (
    .clk(clk), .rst(rst), .load(load),
    .hr_in(hr_code), .lr_in(lr_code),
    .hr_act(hr_act), .lr_act(lr_act), .slots(slots)
  );

  tbase_hr_div #(.CODE_W(HR_CODE_W)) i_hr (
    .clk(clk), .rst(rst), .en(en), .div_code(hr_act),
    .tick(hr_tick), .phase(hr_phase), .wrap(hr_wrap)
  );

  tbase_loop_div #(.CODE_W(LR_CODE_W)) i_loop (
    .clk(clk), .rst(rst), .en(en), .hr_wrap(hr_wrap), .div_code(lr_act),
    .loop_start(loop_start), .wrap(loop_wrap)
  );

  // R3: a loop start never appears without an HR tick
  a_r3_loop_on_tick: assert property (@(posedge clk) disable iff (rst)
    loop_start |-> hr_tick);

  // R6: one cycle of disable silences both enables and clears the phase
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!hr_tick && !loop_start && hr_phase == '0));

  // R4/R5: while running, the slot budget moves only together with a loop start
  a_r5_slots_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst) && !loop_start) |-> $stable(slots));
endmodule

// File: tb/test_tbase_gen.sv
module test_tbase_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [5:0] hr_code = 6'd0;
  logic [2:0] lr_code = 3'd0;
  logic       hr_tick;
  logic       loop_start;
  logic [5:0] hr_phase;
  logic [13:0] slots;

  int checks = 0;
  int failures = 0;
  int k = 0;
  int m_div = 1;
  int m_ldiv = 1;
  int m_start = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tbase_gen i_tbase_gen (
    .clk(clk), .rst(rst), .en(en), .hr_code(hr_code), .lr_code(lr_code),
    .hr_tick(hr_tick), .loop_start(loop_start), .hr_phase(hr_phase), .slots(slots)
  );

  // stimulus table: {hr_code, lr_code, cycles to run}
  localparam int NV = 7;
  localparam logic [24:0] VEC [NV] = '{
    {6'd0,  3'd0, 16'd20},
    {6'd1,  3'd0, 16'd24},
    {6'd0,  3'd3, 16'd40},
    {6'd5,  3'd2, 16'd100},
    {6'd63, 3'd0, 16'd200},
    {6'd2,  3'd7, 16'd800},
    {6'd63, 3'd7, 16'd8300}   // R8 extreme setting
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s k=%0d actual=%0d expected=%0d", req, k, act, exp);
    end
  endtask

  function automatic int prod(input logic [5:0] h, input logic [2:0] l);
    return (int'(h) + 1) * (1 << l);
  endfunction

  // begin a model run: the next rising edge is the first enabled edge
  task automatic model_start();
    m_div   = int'(hr_code) + 1;
    m_ldiv  = 1 << lr_code;
    m_start = k;
  endtask

  // advance one cycle and compare every output with the model of R2/R3/R4/R7
  task automatic run_cycle();
    int rel;
    bit e_tick, e_loop;
    int e_phase;
    @(negedge clk);
    k++;
    rel     = k - m_start;
    e_tick  = (rel % m_div) == 0;
    e_loop  = (rel % (m_div * m_ldiv)) == 0;
    e_phase = rel % m_div;
    chk(hr_tick == e_tick, "R2 hr_tick", int'(hr_tick), int'(e_tick));
    chk(loop_start == e_loop, "R3 loop_start", int'(loop_start), int'(e_loop));
    chk(int'(hr_phase) == e_phase, "R7 hr_phase", int'(hr_phase), e_phase);
    if (e_loop) begin
      m_div   = int'(hr_code) + 1;
      m_ldiv  = 1 << lr_code;
      m_start = k;
    end
    chk(int'(slots) == m_div * m_ldiv, "R4 slots", int'(slots), m_div * m_ldiv);
  endtask

  task automatic idle_cycle(input logic [5:0] h, input logic [2:0] l);
    hr_code = h;
    lr_code = l;
    @(negedge clk);
    k++;
    chk(!hr_tick, "R6 hr_tick idle", int'(hr_tick), 0);
    chk(!loop_start, "R6 loop_start idle", int'(loop_start), 0);
    chk(hr_phase == 6'd0, "R6 hr_phase idle", int'(hr_phase), 0);
    chk(int'(slots) == prod(h, l), "R4 slots idle", int'(slots), prod(h, l));
  endtask

  initial begin
    // R1: reset state
    hr_code = 6'd4; lr_code = 3'd2;
    repeat (3) @(negedge clk);
    chk(!hr_tick && !loop_start, "R1 enables in reset", int'({hr_tick, loop_start}), 0);
    chk(hr_phase == 6'd0, "R1 phase in reset", int'(hr_phase), 0);
    chk(int'(slots) == 20, "R1 slots in reset", int'(slots), 20);
    rst = 1'b0;

    // table walk: R2, R3, R4, R7, R8
    for (int v = 0; v < NV; v++) begin
      en = 1'b0;
      idle_cycle(VEC[v][24:19], VEC[v][18:16]);
      en = 1'b1;
      model_start();
      for (int c = 0; c < int'(VEC[v][15:0]); c++) run_cycle();
    end

    // R6: disabled with changing codes
    en = 1'b0;
    for (int c = 0; c < 20; c++) idle_cycle(6'(c * 3), 3'(c));

    // R5: change of codes in the middle of a loop (old period 6, new period 4)
    idle_cycle(6'd2, 3'd1);
    en = 1'b1;
    model_start();
    run_cycle(); run_cycle();
    hr_code = 6'd0; lr_code = 3'd2;
    run_cycle();
    chk(hr_tick, "R5 old tick kept", int'(hr_tick), 1);
    chk(int'(slots) == 6, "R5 slots kept", int'(slots), 6);
    run_cycle();
    chk(!hr_tick, "R5 old spacing kept", int'(hr_tick), 0);
    run_cycle(); run_cycle();
    chk(loop_start && int'(slots) == 4, "R5 switch at boundary",
        int'(slots), 4);
    for (int c = 0; c < 20; c++) run_cycle();

    // R1: reset in the middle of a run, then restart with en held high
    hr_code = 6'd3; lr_code = 3'd1;
    for (int c = 0; c < 7; c++) run_cycle();
    rst = 1'b1;
    @(negedge clk);
    k++;
    chk(!hr_tick && !loop_start && hr_phase == 6'd0, "R1 mid-run reset",
        int'({hr_tick, loop_start, hr_phase}), 0);
    chk(int'(slots) == 8, "R1 slots after reset", int'(slots), 8);
    rst = 1'b0;
    model_start();
    for (int c = 0; c < 40; c++) run_cycle();

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule